// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block sizes one instruction of a byte-coded instruction set in which every operand has its own addressing specifier. A front end hands it a window of bytes that starts at an instruction boundary, together with the number of operand specifiers and the operand data size that the opcode implies. The decoder then walks the specifiers one per clock. For each one it records where the specifier starts, works out how many bytes the specifier occupies, and finally reports the total instruction length, or flags the encoding as illegal.

A specifier byte carries its addressing mode in bits 7:4 and its register number in bits 3:0. The length of a specifier depends on the mode, on an optional index prefix byte placed in front of the base specifier, and on whether the register is r15, the program counter. In that case autoincrement becomes an immediate whose size is the operand data size, and autoincrement-deferred becomes a 4-byte absolute address. Opcode tables and the fetching of operand values belong to neighbouring blocks.

Top module: `ild_len_decoder`

## Requirements
- R1: After reset, `done_o`, `illegal_o`, `length_o` and every offset slot of `spec_offs_o` are zero.
- R2: Byte 0 of the window (bits 7:0) is the single opcode byte, so an instruction with an operand count of zero has length 1.
- R3: A specifier whose mode (bits 7:4) is 0 to 3 (short literal), 5 (register), 6 (register deferred) or 7 (autodecrement) is one byte long, and so is mode 8 or 9 with a register other than 15.
- R4: Modes 0xA/0xB add 1 trailing displacement byte, 0xC/0xD add 2 and 0xE/0xF add 4.
- R5: Mode 4 is an index prefix: the specifier takes one extra byte in front of the base specifier that follows it, so register, word displacement and indexed register-deferred operands after the opcode give a length of 7.
- R6: Mode 8 with register 15 is an immediate whose trailing byte count is the operand size, encoded on `opnd_size_i` as 0→1, 1→2, 2→4, 3→8 bytes.
- R7: Mode 9 with register 15 is an absolute address with 4 trailing bytes.
- R8: An index prefix whose base specifier has mode 0 to 5 (literal, another index prefix or register) raises `illegal_o` with `length_o` zero.
- R9: A total length beyond the 16-byte window, or an operand count above 6, raises `illegal_o` with `length_o` zero.
- R10: At done, for a legal instruction, slot k of `spec_offs_o` (bits k*6+5 : k*6) holds the byte offset where specifier k begins, counting an index prefix as the start. Unused slots are zero.
- R11: `done_o` is a one-cycle pulse on the max(N,1)-th rising edge after the edge that accepted the window, where N is the operand count. `length_o` and `illegal_o` hold until the next done.
- R12: `win_valid_i` is ignored while an instruction is being decoded. No extra done results, and the result in progress is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid_i | input | 1 | Window strobe, taken when idle |
| win_bytes_i | input | 128 | Instruction bytes, byte k at bits 8k+7:8k |
| opnd_cnt_i | input | 3 | Number of operand specifiers |
| opnd_size_i | input | 2 | Operand data size code |
| done_o | output | 1 | Result pulse |
| illegal_o | output | 1 | Illegal encoding or overrun |
| length_o | output | 6 | Instruction length in bytes, zero when illegal |
| spec_offs_o | output | 36 | Start offset of each specifier, 6 bits per slot |

## Verification
The bench aims at the register-15 cases: immediates of all four sizes and the absolute form. A decoder that ignored the register field would make these one byte long, and one that used a fixed size would miscount every size but one. Index prefixes are tried in front of legal bases and in front of literal, register and index bases. A decoder that forgot the prefix byte would fall one byte short and shift every later offset, and one that skipped the base check would report a length for a bad encoding. A length of exactly 16 bytes, a length beyond 16 bytes and a count of seven guard the window limit, where an off-by-one in the limit would flip the result. A strobe driven in the middle of a decode would produce an extra done pulse, or a wrong result, in a decoder that did not block it.

// File: rtl/ild_pkg.sv
package ild_pkg;

  // Largest specifier: index prefix + base byte + 8-byte immediate.
  localparam int SPEC_MAX = 10;

  typedef enum logic [3:0] {
    AM_IDX    = 4'h4,
    AM_REG    = 4'h5,
    AM_REGDEF = 4'h6,
    AM_AUTODEC = 4'h7,
    AM_AUTOINC = 4'h8,
    AM_AINCDEF = 4'h9
  } addr_mode_e;

  localparam logic [3:0] PC_REG = 4'hF;

  // Operand size code to byte count.
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // Bytes that trail a base specifier byte.
  function automatic logic [3:0] tail_bytes(input logic [3:0] mode,
                                            input logic [3:0] rn,
                                            input logic [1:0] sz);
    logic [3:0] t;
    case (mode)
      AM_AUTOINC:  t = (rn == PC_REG) ? size_bytes(sz) : 4'd0;
      AM_AINCDEF:  t = (rn == PC_REG) ? 4'd4 : 4'd0;
      4'hA, 4'hB:  t = 4'd1;
      4'hC, 4'hD:  t = 4'd2;
      4'hE, 4'hF:  t = 4'd4;
      default:     t = 4'd0;
    endcase
    return t;
  endfunction

  // A base behind an index prefix must address memory: modes 6 and up.
  function automatic logic index_base_ok(input logic [3:0] mode);
    return mode >= AM_REGDEF;
  endfunction

endpackage

// File: rtl/ild_byte_pick.sv
module ild_byte_pick #(
  parameter int WIN_BYTES = 16,
  parameter int IDX_W     = 7
) (
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [7:0]             byte_o
);
  // Positions past the window read as zero.
  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (idx_i == IDX_W'(i)) byte_o = win_i[i*8 +: 8];
    end
  end
endmodule

// File: rtl/ild_spec_decode.sv
module ild_spec_decode
  import ild_pkg::*;
(
  input  logic [7:0] lead_i,
  input  logic [7:0] next_i,
  input  logic [1:0] size_i,
  output logic [4:0] span_o,
  output logic       indexed_o,
  output logic       bad_o
);
  logic [7:0] base_byte;
  logic [3:0] tail;

  always_comb begin
    indexed_o = (lead_i[7:4] == AM_IDX);
    base_byte = indexed_o ? next_i : lead_i;
    tail      = tail_bytes(base_byte[7:4], base_byte[3:0], size_i);
    span_o    = 5'(indexed_o) + 5'd1 + {1'b0, tail};
    bad_o     = indexed_o && !index_base_ok(base_byte[7:4]);
  end

  // R4
  always_comb begin
    span_range_chk: assert (span_o >= 5'd1 && span_o <= 5'(SPEC_MAX));
  end

  // R5
  always_comb begin
    index_span_chk: assert (!indexed_o || span_o >= 5'd2);
  end
endmodule

// File: rtl/ild_offset_table.sv
module ild_offset_table #(
  parameter int SLOTS = 6,
  parameter int OFF_W = 6,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [OFF_W-1:0]       wr_val_i,
  output logic [SLOTS*OFF_W-1:0] offs_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [OFF_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) val_q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g)) val_q <= wr_val_i;
    end
    assign offs_o[g*OFF_W +: OFF_W] = val_q;

    if (g > 0) begin : g_order
      // R10
      offs_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i && wr_idx_i == IDX_W'(g))
          |-> (wr_val_i > offs_o[(g-1)*OFF_W +: OFF_W]));
    end
  end
endmodule

// File: rtl/ild_len_decoder.sv
module ild_len_decoder
  import ild_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int MAX_OPS   = 6,
  parameter int CNT_W     = 3,
  parameter int LEN_W     = $clog2(1 + MAX_OPS*SPEC_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     win_valid_i,
  input  logic [WIN_BYTES*8-1:0]   win_bytes_i,
  input  logic [CNT_W-1:0]         opnd_cnt_i,
  input  logic [1:0]               opnd_size_i,
  output logic                     done_o,
  output logic                     illegal_o,
  output logic [LEN_W-1:0]         length_o,
  output logic [MAX_OPS*LEN_W-1:0] spec_offs_o
);
  // Cursor wide enough for the largest count the port can carry.
  localparam int CUR_W = $clog2(1 + ((1 << CNT_W) - 1)*SPEC_MAX + 1);
  localparam logic [CUR_W-1:0] WIN_LIM = CUR_W'(WIN_BYTES);
  localparam logic [CNT_W-1:0] OPS_LIM = CNT_W'(MAX_OPS);

  logic                   busy_q;
  logic [WIN_BYTES*8-1:0] win_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       idx_q;
  logic [1:0]             size_q;
  logic [CUR_W-1:0]       cur_q;
  logic                   bad_q;
  logic                   done_q;
  logic                   ill_q;
  logic [LEN_W-1:0]       len_q;

  // Named internal events
  logic             accept;
  logic             have_spec;
  logic             finish;
  logic             slot_wr;
  logic [7:0]       lead_byte;
  logic [7:0]       next_byte;
  logic [4:0]       span;
  logic             spec_indexed;
  logic             spec_bad;
  logic [CUR_W-1:0] cur_next;
  logic             bad_next;
  logic             final_bad;

  assign accept    = win_valid_i && !busy_q;
  assign have_spec = busy_q && (cnt_q != '0);
  assign finish    = busy_q && ((cnt_q == '0) || (idx_q == cnt_q - 1'b1));
  assign slot_wr   = have_spec && (idx_q < OPS_LIM);

  ild_byte_pick #(.WIN_BYTES(WIN_BYTES), .IDX_W(CUR_W)) u_pick_lead (
    .win_i (win_q),
    .idx_i (cur_q),
    .byte_o(lead_byte)
  );

  ild_byte_pick #(.WIN_BYTES(WIN_BYTES), .IDX_W(CUR_W)) u_pick_next (
    .win_i (win_q),
    .idx_i (cur_q + 1'b1),
    .byte_o(next_byte)
  );

  ild_spec_decode u_spec (
    .lead_i   (lead_byte),
    .next_i   (next_byte),
    .size_i   (size_q),
    .span_o   (span),
    .indexed_o(spec_indexed),
    .bad_o    (spec_bad)
  );

  ild_offset_table #(.SLOTS(MAX_OPS), .OFF_W(LEN_W), .IDX_W(CNT_W)) u_offs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (accept),
    .wr_en_i (slot_wr),
    .wr_idx_i(idx_q),
    .wr_val_i(cur_q[LEN_W-1:0]),
    .offs_o  (spec_offs_o)
  );

  always_comb begin
    cur_next  = cur_q + (have_spec ? CUR_W'(span) : '0);
    bad_next  = bad_q | (have_spec & spec_bad);
    final_bad = bad_next | (cur_next > WIN_LIM) | (cnt_q > OPS_LIM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      win_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      size_q <= '0;
      cur_q  <= '0;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        win_q  <= win_bytes_i;
        cnt_q  <= opnd_cnt_i;
        size_q <= opnd_size_i;
        idx_q  <= '0;
        cur_q  <= CUR_W'(1);
        bad_q  <= 1'b0;
      end else if (busy_q) begin
        cur_q <= cur_next;
        idx_q <= idx_q + 1'b1;
        bad_q <= bad_next;
        if (finish) begin
          busy_q <= 1'b0;
          ill_q  <= final_bad;
          len_q  <= final_bad ? '0 : cur_next[LEN_W-1:0];
        end
      end
    end
  end

  assign done_o    = done_q;
  assign illegal_o = ill_q;
  assign length_o  = len_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_q));

  // R12
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(cnt_q) && $stable(size_q) && $stable(win_q)));

  // R2
  legal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !illegal_o)
      |-> (int'(length_o) > int'(cnt_q) && int'(length_o) <= WIN_BYTES));
endmodule

// File: tb/ild_len_decoder_bench.sv
`timescale 1ns/1ps
module ild_len_decoder_bench;
  localparam int WB = 16;
  localparam int MO = 6;
  localparam int LW = 6;

  typedef logic [7:0] blist_t [$];
  typedef struct {
    int              len;
    bit              ill;
    logic [MO*LW-1:0] offs;
    int              due;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              win_valid = 1'b0;
  logic [WB*8-1:0]   win_bytes = '0;
  logic [2:0]        opnd_cnt = '0;
  logic [1:0]        opnd_size = '0;
  logic              done;
  logic              illegal;
  logic [LW-1:0]     length;
  logic [MO*LW-1:0]  offs;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ild_len_decoder u_ild_len_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_valid_i(win_valid),
    .win_bytes_i(win_bytes),
    .opnd_cnt_i (opnd_cnt),
    .opnd_size_i(opnd_size),
    .done_o     (done),
    .illegal_o  (illegal),
    .length_o   (length),
    .spec_offs_o(offs)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [WB*8-1:0] w, input int p);
    if (p >= WB) return 8'h00;
    return w[p*8 +: 8];
  endfunction

  // Reference sizing, written from the requirements.
  function automatic void model(input logic [WB*8-1:0] w, input int cnt, input int sz,
                                output int len, output bit ill,
                                output logic [MO*LW-1:0] ov);
    int pos;
    bit bad;
    pos = 1;
    bad = 0;
    ov = '0;
    for (int k = 0; k < cnt; k++) begin
      logic [7:0] sb;
      int m;
      int r;
      if (k < MO) ov[k*LW +: LW] = LW'(pos);
      sb = byte_at(w, pos);
      if (sb[7:4] == 4'h4) begin
        pos++;
        sb = byte_at(w, pos);
        if (sb[7:4] <= 4'h5) bad = 1;
      end
      m = int'(sb[7:4]);
      r = int'(sb[3:0]);
      pos++;
      if (m >= 14)               pos += 4;
      else if (m >= 12)          pos += 2;
      else if (m >= 10)          pos += 1;
      else if (m == 8 && r == 15) pos += (1 << sz);
      else if (m == 9 && r == 15) pos += 4;
    end
    if (cnt > MO || pos > WB) bad = 1;
    ill = bad;
    len = bad ? 0 : pos;
  endfunction

  // Monitor: pops one expected item per done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12", "unexpected done", 1, 0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(illegal) == int'(e.ill), t, "illegal", longint'(illegal), longint'(e.ill));
        check(int'(length) == e.len, t, "length", longint'(length), longint'(e.len));
        if (!e.ill)
          check(offs == e.offs, t, "offsets(R10)", longint'(offs), longint'(e.offs));
        check(cyc == e.due, "R11", "done cycle", longint'(cyc), longint'(e.due));
      end
    end
  end

  // Driver: builds the window, predicts the result, pulses the strobe.
  task automatic send(input blist_t bl, input int cnt, input int sz,
                      input string tag, input bit poke);
    logic [WB*8-1:0] w;
    exp_t e;
    int lat;
    w = '0;
    foreach (bl[i]) if (i < WB) w[i*8 +: 8] = bl[i];
    model(w, cnt, sz, e.len, e.ill, e.offs);
    @(negedge clk);
    lat = (cnt > 1) ? cnt : 1;
    e.due = cyc + 1 + lat;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    win_bytes = w;
    opnd_cnt  = 3'(cnt);
    opnd_size = 2'(sz);
    win_valid = 1'b1;
    @(negedge clk);
    win_valid = 1'b0;
    if (poke) begin
      // R12: strobe a different window while decoding is under way
      win_bytes = {WB{8'hE1}};
      opnd_cnt  = 3'd1;
      win_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      win_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1", "done", longint'(done), 0);
    check(illegal == 1'b0, "R1", "illegal", longint'(illegal), 0);
    check(length == '0, "R1", "length", longint'(length), 0);
    check(offs == '0, "R1", "offsets", longint'(offs), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send('{8'h01}, 0, 0, "R2", 0);
    send('{8'hC1, 8'h51, 8'hC2, 8'hD9, 8'h02, 8'h44, 8'h63}, 3, 2, "R5", 0);
    send('{8'h10, 8'h05, 8'h57, 8'h63, 8'h74, 8'h88, 8'h93}, 6, 2, "R3", 0);
    send('{8'h20, 8'hA1, 8'h10, 8'hE2, 8'h1, 8'h2, 8'h3, 8'h4,
           8'hB3, 8'hFF, 8'hD4, 8'h00, 8'h01}, 4, 1, "R4", 0);
    for (int s = 0; s < 4; s++)
      send('{8'h30, 8'h8F, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
             8'h77, 8'h88, 8'h56}, 2, s, "R6", 0);
    send('{8'h31, 8'h9F, 8'h0, 8'h1, 8'h0, 8'h2, 8'h99}, 2, 0, "R7", 0);
    send('{8'h32, 8'h42, 8'hA3, 8'h10, 8'h45, 8'h8F, 8'h1, 8'h2, 8'h3, 8'h4},
         2, 2, "R5", 0);
    send('{8'h40, 8'h41, 8'h52}, 1, 2, "R8", 0);
    send('{8'h40, 8'h41, 8'h42, 8'h63}, 1, 2, "R8", 0);
    send('{8'h40, 8'h51, 8'h41, 8'h03}, 2, 2, "R8", 0);
    send('{8'h50, 8'hE1, 8'h0, 8'h0, 8'h0, 8'h0, 8'hE2, 8'h0, 8'h0, 8'h0,
           8'h0, 8'hE3, 8'h0, 8'h0, 8'h0, 8'h0}, 3, 2, "R9", 0);
    send('{8'h51, 8'h8F, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7, 8'h8,
           8'h8F, 8'h1, 8'h2}, 2, 3, "R9", 0);
    send('{8'h52, 8'h50, 8'h51, 8'h52, 8'h53, 8'h54, 8'h55, 8'h56}, 7, 2, "R9", 0);
    send('{8'h60, 8'h51, 8'hA2, 8'h04, 8'h63, 8'h74, 8'h55}, 5, 2, "R12", 1);
    send('{8'h61, 8'hC7, 8'h00, 8'h10}, 1, 2, "R10", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule